// File: doc/BRIEF.md
# Multi-Width Barrel Shifter Unit

This unit shifts, rotates or scales an operand of 16, 32 or 40 bits, chosen per operation. It covers arithmetic and logical shifts whose direction is set by the sign of the shift amount, an arithmetic left shift that can clamp on overflow, and a rotate that passes through an external condition bit. It also has two fused add-and-shift forms and a count of redundant sign bits for exponent detection. The shift amount comes either from a short signed immediate or from a 16-bit signed register half.

All results are computed in one combinational pass and captured in one output register, so a result appears one clock after its inputs. Three width lanes run side by side and the width select picks one of them. The result bits above the selected width read as zero.

Top module: `mw_shifter`

## Requirements
- R1: Width select 0 picks 16 bits, 1 picks 32 bits, 2 and 3 pick 40 bits. Only the low bits of the operands up to that width are used. Result bits above the width are zero. Outputs are registered, so a result appears at the clock edge after its inputs are applied.
- R2: While the asynchronous active-low reset is asserted, result, condition-out and overflow are all zero.
- R3: With amount source 0 the amount is the 6-bit signed immediate; with source 1 it is the 16-bit signed register value and the immediate has no effect. A positive amount shifts left, a negative amount shifts right, and zero leaves the operand unchanged.
- R4: Operation 0 (arithmetic shift) fills from the sign bit when shifting right. A magnitude at or beyond the width gives all sign bits to the right and zero to the left.
- R5: Operation 2 (logical shift) fills with zeros in both directions. A magnitude at or beyond the width gives zero.
- R6: For operations 0 and 1, overflow is set on a left shift when the bits shifted out and the result sign bit are not all equal. Operation 0 still returns the truncated value. Every other operation leaves overflow at 0.
- R7: Operation 1 (saturating arithmetic shift) returns the most positive value (0111..1) for a non-negative operand, or the most negative value (1000..0) for a negative one, whenever overflow is set. Otherwise it acts as operation 0.
- R8: Operation 3 rotates the (width+1)-bit value {condition-in, operand} by the amount taken modulo width+1, left for positive amounts and right for negative ones. The result is the low part of the rotated value and condition-out is its top bit, which is the last bit rotated out of the operand.
- R9: Every operation other than 3 copies condition-in to condition-out.
- R10: Operation 4 returns (A+B) shifted left, and operation 5 returns A + (B shifted left), both truncated to the width. The shift is 2 places when bit 1 of the selected amount is set, otherwise 1 place.
- R11: Operation 6 returns the number of bits directly below the operand's top bit that equal it, which is the count of redundant sign bits.
- R12: Operation 7 returns operand A unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa | input | 40 | Operand A (value that is shifted) |
| opb | input | 40 | Operand B (addend for operations 4 and 5) |
| wsel | input | 2 | Width select |
| op | input | 3 | Operation select |
| amt_src | input | 1 | Amount source: 0 immediate, 1 register |
| amt_imm | input | 6 | Signed immediate amount |
| amt_reg | input | 16 | Signed register amount |
| cc_in | input | 1 | Condition bit in |
| result | output | 40 | Registered result, zero above the selected width |
| cc_out | output | 1 | Registered condition bit out |
| ovf | output | 1 | Registered overflow flag |

## Verification
The bench builds the unit with its default parameters: lanes of 16, 32 and 40 bits, a 6-bit immediate and a 16-bit register amount. The 16-bit register amount reaches magnitudes of 40 and beyond, which exercises the saturate-to-width paths of every lane. The 6-bit immediate reaches 17, which exercises the wrap of the 17-bit rotate in the narrow lane. The 40-bit lane also covers the zero-extension of narrower results into the full output.

// File: rtl/bs_pkg.sv
package bs_pkg;

    typedef enum logic [2:0] {
        OP_ASH     = 3'd0,
        OP_ASH_SAT = 3'd1,
        OP_LSH     = 3'd2,
        OP_ROT     = 3'd3,
        OP_ADDSH   = 3'd4,
        OP_SHADD   = 3'd5,
        OP_SIGNS   = 3'd6,
        OP_PASS    = 3'd7
    } bs_op_e;

endpackage

// File: rtl/bs_amount_dec.sv
module bs_amount_dec #(
    parameter int IMM_W = 6,
    parameter int AMT_W = 16
) (
    input  logic             src_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [AMT_W-1:0] reg_i,
    output logic             left_o,
    output logic [AMT_W-1:0] mag_o,
    output logic             two_places_o
);

    logic [AMT_W-1:0] amt;

    always_comb begin
        amt          = src_i ? reg_i : {{(AMT_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
        left_o       = ~amt[AMT_W-1];
        mag_o        = amt[AMT_W-1] ? (~amt + 1'b1) : amt;
        two_places_o = amt[1];
    end

endmodule

// File: rtl/bs_lane.sv
module bs_lane
    import bs_pkg::*;
#(
    parameter int W     = 16,
    parameter int AMT_W = 16
) (
    input  bs_op_e           op_i,
    input  logic [W-1:0]     x_i,
    input  logic [W-1:0]     y_i,
    input  logic             left_i,
    input  logic [AMT_W-1:0] mag_i,
    input  logic             two_places_i,
    input  logic             cc_i,
    output logic [W-1:0]     res_o,
    output logic             cc_o,
    output logic             ovf_o
);

    localparam int CW = $clog2(W + 1);
    localparam logic [AMT_W-1:0] W_A  = AMT_W'(W);
    localparam logic [AMT_W-1:0] W1_A = AMT_W'(W + 1);

    logic [CW-1:0]    shc;
    logic [2*W-1:0]   wide;
    logic [W:0]       wide_top;
    logic             ovf_left;
    logic [W-1:0]     left_v;
    logic [W-1:0]     arith_r;
    logic [W-1:0]     logic_r;
    logic [W-1:0]     sat_v;
    logic [AMT_W-1:0] rmod;
    logic [AMT_W-1:0] rl;
    logic [W:0]       rv;
    logic [2*W+1:0]   dbl;
    logic [W:0]       rot_v;
    logic [W-1:0]     sum_v;
    logic [W-1:0]     addsh_v;
    logic [W-1:0]     shadd_v;
    logic [CW-1:0]    sgn_cnt;
    logic             sgn_run;

    // Shift engine: clamp the magnitude to the width, then one shifter per direction
    always_comb begin
        shc      = (mag_i >= W_A) ? CW'(W) : mag_i[CW-1:0];
        wide     = {{W{x_i[W-1]}}, x_i} << shc;
        wide_top = wide[2*W-1:W-1];
        ovf_left = left_i && !(&wide_top) && (|wide_top);
        left_v   = x_i << shc;
        arith_r  = W'($signed(x_i) >>> shc);
        logic_r  = x_i >> shc;
        sat_v    = x_i[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end

    // Rotate through the condition bit: a (W+1)-bit ring
    always_comb begin
        rmod  = mag_i % W1_A;
        rl    = left_i ? rmod : ((rmod == '0) ? '0 : (W1_A - rmod));
        rv    = {cc_i, x_i};
        dbl   = {rv, rv} << rl;
        rot_v = dbl[2*W+1:W+1];
    end

    // Fused add/shift and redundant sign count
    always_comb begin
        sum_v   = x_i + y_i;
        addsh_v = two_places_i ? (sum_v << 2) : (sum_v << 1);
        shadd_v = x_i + (two_places_i ? (y_i << 2) : (y_i << 1));
        sgn_cnt = '0;
        sgn_run = 1'b1;
        for (int i = W - 2; i >= 0; i--) begin
            if (sgn_run && (x_i[i] == x_i[W-1])) begin
                sgn_cnt = sgn_cnt + 1'b1;
            end else begin
                sgn_run = 1'b0;
            end
        end
    end

    always_comb begin
        res_o = x_i;
        cc_o  = cc_i;
        ovf_o = 1'b0;
        unique case (op_i)
            OP_ASH: begin
                res_o = left_i ? left_v : arith_r;
                ovf_o = ovf_left;
            end
            OP_ASH_SAT: begin
                res_o = left_i ? (ovf_left ? sat_v : left_v) : arith_r;
                ovf_o = ovf_left;
            end
            OP_LSH:   res_o = left_i ? left_v : logic_r;
            OP_ROT: begin
                res_o = rot_v[W-1:0];
                cc_o  = rot_v[W];
            end
            OP_ADDSH: res_o = addsh_v;
            OP_SHADD: res_o = shadd_v;
            OP_SIGNS: res_o = W'(sgn_cnt);
            OP_PASS:  res_o = x_i;
            default:  res_o = x_i;
        endcase
    end

    // R11: the sign count of a W-bit value never reaches W
    always_comb begin
        if (op_i == OP_SIGNS) begin
            a_r11_count_below_width: assert (res_o < W'(W));
        end
    end

endmodule

// File: rtl/mw_shifter.sv
module mw_shifter
    import bs_pkg::*;
#(
    parameter int NARROW_W = 16,
    parameter int MID_W    = 32,
    parameter int WIDE_W   = 40,
    parameter int IMM_W    = 6,
    parameter int AMT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDE_W-1:0] opa,
    input  logic [WIDE_W-1:0] opb,
    input  logic [1:0]        wsel,
    input  logic [2:0]        op,
    input  logic              amt_src,
    input  logic [IMM_W-1:0]  amt_imm,
    input  logic [AMT_W-1:0]  amt_reg,
    input  logic              cc_in,
    output logic [WIDE_W-1:0] result,
    output logic              cc_out,
    output logic              ovf
);

    localparam int N_LANES = 3;
    localparam int LANE_W [N_LANES] = '{NARROW_W, MID_W, WIDE_W};

    typedef struct packed {
        logic [WIDE_W-1:0] result;
        logic              cc;
        logic              ovf;
    } out_t;

    out_t             st_d, st_q;
    logic             armed_d, armed_q;
    bs_op_e           op_e;
    logic             left;
    logic [AMT_W-1:0] mag;
    logic             two_places;
    logic [1:0]       lane_idx;

    logic [WIDE_W-1:0] lane_res [N_LANES];
    logic              lane_cc  [N_LANES];
    logic              lane_ovf [N_LANES];

    assign op_e = bs_op_e'(op);

    bs_amount_dec #(
        .IMM_W (IMM_W),
        .AMT_W (AMT_W)
    ) amt_i (
        .src_i        (amt_src),
        .imm_i        (amt_imm),
        .reg_i        (amt_reg),
        .left_o       (left),
        .mag_o        (mag),
        .two_places_o (two_places)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int LW = LANE_W[g];
        logic [LW-1:0] lane_r;

        bs_lane #(
            .W     (LW),
            .AMT_W (AMT_W)
        ) lane_i (
            .op_i         (op_e),
            .x_i          (opa[LW-1:0]),
            .y_i          (opb[LW-1:0]),
            .left_i       (left),
            .mag_i        (mag),
            .two_places_i (two_places),
            .cc_i         (cc_in),
            .res_o        (lane_r),
            .cc_o         (lane_cc[g]),
            .ovf_o        (lane_ovf[g])
        );

        assign lane_res[g] = WIDE_W'(lane_r);
    end

    always_comb begin
        lane_idx    = (wsel == 2'd0) ? 2'd0 : ((wsel == 2'd1) ? 2'd1 : 2'd2);
        st_d.result = lane_res[lane_idx];
        st_d.cc     = lane_cc[lane_idx];
        st_d.ovf    = lane_ovf[lane_idx];
        armed_d     = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            armed_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            armed_q <= armed_d;
        end
    end

    assign result = st_q.result;
    assign cc_out = st_q.cc;
    assign ovf    = st_q.ovf;

    // R1: a narrow result carries nothing above its width
    a_r1_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(wsel) == 2'd0) |-> (result[WIDE_W-1:NARROW_W] == '0));

    // R9: only the rotate changes the condition bit
    a_r9_cc_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op) != 3'd3) |-> (cc_out == $past(cc_in)));

    // R6: overflow is reported only by the arithmetic shifts
    a_r6_ovf_only_ashift: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op) != 3'd0 && $past(op) != 3'd1) |-> !ovf);

    // R7: a saturated narrow result is one of the two extremes
    a_r7_sat_extreme: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ovf && $past(op) == 3'd1 && $past(wsel) == 2'd0) |->
        (result == WIDE_W'(16'h7FFF) || result == WIDE_W'(16'h8000)));

    // R12: the pass operation returns the full-width operand
    a_r12_pass_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op) == 3'd7 && $past(wsel) == 2'd2) |-> (result == $past(opa)));

endmodule

// File: tb/mw_shifter_tb_top.sv
module mw_shifter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] opa = '0;
    logic [39:0] opb = '0;
    logic [1:0]  wsel = '0;
    logic [2:0]  op = '0;
    logic        amt_src = 1'b0;
    logic [5:0]  amt_imm = '0;
    logic [15:0] amt_reg = '0;
    logic        cc_in = 1'b0;
    logic [39:0] result;
    logic        cc_out;
    logic        ovf;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    mw_shifter dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .opa     (opa),
        .opb     (opb),
        .wsel    (wsel),
        .op      (op),
        .amt_src (amt_src),
        .amt_imm (amt_imm),
        .amt_reg (amt_reg),
        .cc_in   (cc_in),
        .result  (result),
        .cc_out  (cc_out),
        .ovf     (ovf)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [2:0]  op;
        logic [1:0]  wsel;
        logic        src;
        logic [5:0]  imm;
        logic [15:0] rg;
        logic        cc;
        logic [39:0] a;
        logic [39:0] b;
        logic [39:0] er;
        logic        ecc;
        logic        eovf;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{8'd5,  3'd2, 2'd1, 1'b0, 6'h3C, 16'h0000, 1'b0, 40'h00_0000_B6A3, 40'h0, 40'h00_0000_0B6A, 1'b0, 1'b0}, // R5 right 4
        '{8'd5,  3'd2, 2'd1, 1'b0, 6'd4,  16'h0000, 1'b0, 40'h00_0000_B6A3, 40'h0, 40'h00_000B_6A30, 1'b0, 1'b0}, // R5 left 4
        '{8'd1,  3'd2, 2'd0, 1'b0, 6'd4,  16'h0000, 1'b0, 40'h00_0000_B6A3, 40'h0, 40'h00_0000_6A30, 1'b0, 1'b0}, // R1 half-word drop
        '{8'd8,  3'd3, 2'd1, 1'b0, 6'd4,  16'h0000, 1'b0, 40'h00_ABCD_EF12, 40'h0, 40'h00_BCDE_F125, 1'b0, 1'b0}, // R8 rotate left
        '{8'd3,  3'd0, 2'd1, 1'b1, 6'd0,  16'h0004, 1'b0, 40'h00_0000_B6A3, 40'h0, 40'h00_000B_6A30, 1'b0, 1'b0}, // R3 register amount
        '{8'd4,  3'd0, 2'd0, 1'b0, 6'h3C, 16'h0000, 1'b0, 40'h00_0000_B6A3, 40'h0, 40'h00_0000_FB6A, 1'b0, 1'b0}, // R4 sign fill
        '{8'd4,  3'd0, 2'd0, 1'b1, 6'd0,  16'hFFEC, 1'b0, 40'h00_0000_8000, 40'h0, 40'h00_0000_FFFF, 1'b0, 1'b0}, // R4 beyond width
        '{8'd4,  3'd0, 2'd2, 1'b1, 6'd0,  16'hFFD8, 1'b0, 40'h80_0000_0000, 40'h0, 40'hFF_FFFF_FFFF, 1'b0, 1'b0}, // R4 at width 40
        '{8'd5,  3'd2, 2'd2, 1'b1, 6'd0,  16'hFFD8, 1'b0, 40'hFF_FFFF_FFFF, 40'h0, 40'h00_0000_0000, 1'b0, 1'b0}, // R5 at width 40
        '{8'd6,  3'd0, 2'd0, 1'b0, 6'd1,  16'h0000, 1'b0, 40'h00_0000_4000, 40'h0, 40'h00_0000_8000, 1'b0, 1'b1}, // R6 truncated + flag
        '{8'd7,  3'd1, 2'd0, 1'b0, 6'd1,  16'h0000, 1'b0, 40'h00_0000_4000, 40'h0, 40'h00_0000_7FFF, 1'b0, 1'b1}, // R7 clamp positive
        '{8'd7,  3'd1, 2'd0, 1'b0, 6'd4,  16'h0000, 1'b0, 40'h00_0000_B6A3, 40'h0, 40'h00_0000_8000, 1'b0, 1'b1}, // R7 clamp negative
        '{8'd7,  3'd1, 2'd1, 1'b0, 6'd2,  16'h0000, 1'b0, 40'h00_0000_B6A3, 40'h0, 40'h00_0002_DA8C, 1'b0, 1'b0}, // R7 no clamp
        '{8'd7,  3'd1, 2'd0, 1'b0, 6'd1,  16'h0000, 1'b0, 40'h00_0000_C000, 40'h0, 40'h00_0000_8000, 1'b0, 1'b0}, // R7 sign kept
        '{8'd8,  3'd3, 2'd0, 1'b0, 6'h3F, 16'h0000, 1'b1, 40'h00_0000_0001, 40'h0, 40'h00_0000_8000, 1'b1, 1'b0}, // R8 rotate right
        '{8'd8,  3'd3, 2'd0, 1'b0, 6'd17, 16'h0000, 1'b1, 40'h00_0000_1234, 40'h0, 40'h00_0000_1234, 1'b1, 1'b0}, // R8 full ring
        '{8'd8,  3'd3, 2'd0, 1'b0, 6'd1,  16'h0000, 1'b0, 40'h00_0000_8000, 40'h0, 40'h00_0000_0000, 1'b1, 1'b0}, // R8 bit into cc
        '{8'd9,  3'd2, 2'd1, 1'b0, 6'd1,  16'h0000, 1'b1, 40'h00_0000_0001, 40'h0, 40'h00_0000_0002, 1'b1, 1'b0}, // R9 cc kept
        '{8'd10, 3'd4, 2'd0, 1'b0, 6'd1,  16'h0000, 1'b0, 40'h00_0000_0003, 40'h4, 40'h00_0000_000E, 1'b0, 1'b0}, // R10 add then 1
        '{8'd10, 3'd5, 2'd0, 1'b0, 6'd2,  16'h0000, 1'b0, 40'h00_0000_0001, 40'h3, 40'h00_0000_000D, 1'b0, 1'b0}, // R10 shift 2 then add
        '{8'd10, 3'd4, 2'd0, 1'b0, 6'd2,  16'h0000, 1'b0, 40'h00_0000_0100, 40'h200, 40'h00_0000_0C00, 1'b0, 1'b0}, // R10 add then 2
        '{8'd11, 3'd6, 2'd0, 1'b0, 6'd0,  16'h0000, 1'b0, 40'h00_0000_0001, 40'h0, 40'h00_0000_000E, 1'b0, 1'b0}, // R11 positive
        '{8'd11, 3'd6, 2'd1, 1'b0, 6'd0,  16'h0000, 1'b0, 40'h00_FFFF_FFFF, 40'h0, 40'h00_0000_001F, 1'b0, 1'b0}, // R11 all ones
        '{8'd11, 3'd6, 2'd2, 1'b0, 6'd0,  16'h0000, 1'b0, 40'h00_4000_0000, 40'h0, 40'h00_0000_0008, 1'b0, 1'b0}, // R11 width 40
        '{8'd12, 3'd7, 2'd1, 1'b0, 6'd0,  16'h0000, 1'b0, 40'hFF_FFFF_FFFF, 40'h0, 40'h00_FFFF_FFFF, 1'b0, 1'b0}, // R12 pass + R1
        '{8'd1,  3'd2, 2'd3, 1'b0, 6'd4,  16'h0000, 1'b0, 40'h01_0000_0000, 40'h0, 40'h10_0000_0000, 1'b0, 1'b0}, // R1 select 3 is 40
        '{8'd6,  3'd2, 2'd0, 1'b0, 6'd1,  16'h0000, 1'b0, 40'h00_0000_4000, 40'h0, 40'h00_0000_8000, 1'b0, 1'b0}, // R6 logical no flag
        '{8'd6,  3'd0, 2'd1, 1'b1, 6'd0,  16'h0028, 1'b0, 40'h00_0000_0001, 40'h0, 40'h00_0000_0000, 1'b0, 1'b1}, // R6 left past width
        '{8'd3,  3'd0, 2'd0, 1'b0, 6'd0,  16'h0000, 1'b0, 40'h00_0000_8001, 40'h0, 40'h00_0000_8001, 1'b0, 1'b0}, // R3 zero amount
        '{8'd3,  3'd2, 2'd1, 1'b1, 6'd4,  16'hFFFC, 1'b0, 40'h00_0000_B6A3, 40'h0, 40'h00_0000_0B6A, 1'b0, 1'b0}  // R3 immediate ignored
    };

    task automatic check(input int req, input string what, input logic [39:0] act, input logic [39:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        op      = v.op;
        wsel    = v.wsel;
        amt_src = v.src;
        amt_imm = v.imm;
        amt_reg = v.rg;
        cc_in   = v.cc;
        opa     = v.a;
        opb     = v.b;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        // R2: reset state, with busy inputs applied
        apply(VECS[3]);
        repeat (3) @(negedge clk);
        check(2, "reset result", result, 40'h0);
        check(2, "reset cc", {39'h0, cc_out}, 40'h1 & 40'h0);
        check(2, "reset ovf", {39'h0, ovf}, 40'h0);
        rst_n = 1'b1;

        // Vector table: drive at a falling edge, sample at the next one
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            @(negedge clk);
            check(VECS[i].req, $sformatf("vec %0d result", i), result, VECS[i].er);
            check(VECS[i].req, $sformatf("vec %0d cc", i), {39'h0, cc_out}, {39'h0, VECS[i].ecc});
            check(VECS[i].req, $sformatf("vec %0d ovf", i), {39'h0, ovf}, {39'h0, VECS[i].eovf});
        end

        // R1: output holds until the clock edge after new inputs
        @(negedge clk);
        apply(VECS[0]);
        @(negedge clk);
        apply(VECS[1]);
        #1;
        check(1, "latency hold", result, 40'h00_0000_0B6A);
        @(negedge clk);
        check(1, "latency update", result, 40'h00_000B_6A30);

        // R8: register amount far beyond the ring, 41 mod 17 = 7, rotate left
        @(negedge clk);
        op = 3'd3; wsel = 2'd0; amt_src = 1'b1; amt_reg = 16'd41; cc_in = 1'b0; opa = 40'h0001;
        @(negedge clk);
        check(8, "rotate mod ring", result, 40'h0080);

        // R2: reset in mid-run clears a nonzero result at once
        @(negedge clk);
        apply(VECS[10]);
        @(negedge clk);
        check(7, "pre-reset value", result, 40'h7FFF);
        rst_n = 1'b0;
        #1;
        check(2, "mid-run reset result", result, 40'h0);
        check(2, "mid-run reset ovf", {39'h0, ovf}, 40'h0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule